// File: doc/BRIEF.md
# Exception Detection and Vector Unit

This block sits beside the instruction-execute stage of a simple processor. Each cycle it inspects the instruction being executed: its opcode, the overflow flag from the ALU, and the address and direction of any word memory access. It decides whether the instruction faults, and which fault takes precedence when several apply. In the same cycle it removes the instruction's register write and memory write.

One clock later it raises a single-cycle exception strobe. The strobe comes with a cause code, a corrected exception program counter, and the handler address to load into the program counter. The strobe is the select for the extra program-counter source and the capture enable for the exception registers outside this block.

The handler address comes from one of two modes, chosen per instruction by an input. In vectored mode each fault kind has its own entry point, 32 bytes apart from its neighbour. In single-entry mode every fault jumps to one base address, and software reads the cause code. While the strobe is high, the instruction presented at the inputs is being flushed. It is ignored and its writes are blocked.

Top module: `excvec_unit`

## Requirements
- R1: An instruction whose 6-bit opcode is not one of 0x00, 0x02, 0x03, 0x04, 0x05, 0x08, 0x09, 0x0A, 0x0C, 0x0D, 0x0F, 0x23, 0x2B is an undefined-instruction fault with cause code 10.
- R2: A valid instruction with `mem_rd` or `mem_wr` high and either of `mem_addr[1:0]` nonzero is an unaligned-access fault. Its cause code is 4 for a load (`mem_rd`) and 5 for a store (`mem_wr`).
- R3: A valid instruction with `alu_ovf` high is an overflow fault with cause code 12, and `reg_we_out` stays low in that cycle.
- R4: Any faulting instruction drives both `reg_we_out` and `mem_we_out` low in its own cycle. A faulting store therefore never writes memory.
- R5: When several faults apply at once, the undefined instruction wins over the unaligned access, and the unaligned access wins over overflow.
- R6: On the strobe, `exc_cause` carries the 5-bit code of the winning fault. Between strobes, `exc_cause`, `exc_epc` and `handler_pc` hold their last values.
- R7: With `vec_mode` high in the faulting cycle, `handler_pc` is 0xC0000000 for an undefined instruction, 0xC0000020 for overflow and 0xC0000040 for an unaligned access.
- R8: With `vec_mode` low in the faulting cycle, `handler_pc` is 0xC0000180 for every fault kind.
- R9: `exc_epc` is `pc_cur - 4` when `pc_advanced` was high in the faulting cycle, and `pc_cur` otherwise.
- R10: `exc_strobe` is high for exactly the one cycle after a faulting instruction. An instruction presented while the strobe is high cannot fault, and its writes are blocked.
- R11: While `rst` is high, and in the first cycle after it, `exc_strobe`, `exc_cause`, `exc_epc` and `handler_pc` are zero.
- R12: A valid non-faulting instruction outside the strobe cycle passes `reg_we_in` and `mem_wr` through to `reg_we_out` and `mem_we_out`. With `instr_valid` low, both write outputs are low and no strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is executing this cycle |
| opcode | input | 6 | Primary opcode field of the instruction |
| alu_ovf | input | 1 | Signed overflow reported by the ALU |
| mem_rd | input | 1 | Instruction performs a word load |
| mem_wr | input | 1 | Instruction performs a word store |
| mem_addr | input | 32 | Effective memory address |
| pc_cur | input | 32 | Program counter value seen by this stage |
| pc_advanced | input | 1 | `pc_cur` already points past the instruction |
| vec_mode | input | 1 | 1 selects vectored handlers, 0 selects the single entry |
| reg_we_in | input | 1 | Register-file write request of the instruction |
| reg_we_out | output | 1 | Register-file write enable after suppression |
| mem_we_out | output | 1 | Memory write enable after suppression |
| exc_strobe | output | 1 | One-cycle exception capture strobe and PC-source select |
| exc_cause | output | 5 | Cause code of the captured fault |
| exc_epc | output | 32 | Address of the faulting instruction |
| handler_pc | output | 32 | Address to load into the program counter |

## Verification
The assertions assume that `mem_rd` and `mem_wr` are never high together, and that `alu_ovf`, `mem_rd` and `mem_wr` only mean something while `instr_valid` is high. The stimulus therefore derives the store bit from a random bit masked by the inverse of the load bit. It drives every input at the falling edge, so the ALU flag and the access type are stable over each sampling edge. The directed part stacks several faults into one instruction to exercise the priority order. It also presents a second fault during a strobe cycle to confirm that the flushed slot is ignored.

// File: rtl/excvec_pkg.sv
package excvec_pkg;

  localparam int OPC_W   = 6;
  localparam int CAUSE_W = 5;

  // Fault kinds; the numeric value is also the vector slot index.
  typedef enum logic [1:0] {
    KIND_UNDEF = 2'd0,
    KIND_OVF   = 2'd1,
    KIND_UNAL  = 2'd2,
    KIND_NONE  = 2'd3
  } exc_kind_e;

  localparam int NUM_KINDS = 3;
  localparam int KIND_W    = $bits(exc_kind_e);

  localparam logic [CAUSE_W-1:0] CODE_ADDR_LD = 5'd4;
  localparam logic [CAUSE_W-1:0] CODE_ADDR_ST = 5'd5;
  localparam logic [CAUSE_W-1:0] CODE_RSVD    = 5'd10;
  localparam logic [CAUSE_W-1:0] CODE_OVF     = 5'd12;

  typedef struct packed {
    logic               hit;
    exc_kind_e          kind;
    logic [CAUSE_W-1:0] cause;
  } exc_dec_t;

  // Recognised primary opcodes.
  function automatic logic opc_legal(input logic [OPC_W-1:0] op);
    case (op)
      6'h00, 6'h02, 6'h03, 6'h04, 6'h05,
      6'h08, 6'h09, 6'h0A, 6'h0C, 6'h0D,
      6'h0F, 6'h23, 6'h2B: opc_legal = 1'b1;
      default:             opc_legal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/excvec_detect.sv
module excvec_detect
  import excvec_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic             instr_valid,
  input  logic             squash,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_ovf,
  input  logic             mem_rd,
  input  logic             mem_wr,
  input  logic [XLEN-1:0]  mem_addr,
  output exc_dec_t         dec
);

  logic live, f_undef, f_unal, f_ovf;

  always_comb begin
    live    = instr_valid & ~squash;
    f_undef = live & ~opc_legal(opcode);
    f_unal  = live & (mem_rd | mem_wr) & (|mem_addr[ALIGN_BITS-1:0]);
    f_ovf   = live & alu_ovf;

    dec.hit   = f_undef | f_unal | f_ovf;
    dec.kind  = KIND_NONE;
    dec.cause = '0;
    // Fixed precedence: undefined, then unaligned, then overflow.
    if (f_undef) begin
      dec.kind  = KIND_UNDEF;
      dec.cause = CODE_RSVD;
    end else if (f_unal) begin
      dec.kind  = KIND_UNAL;
      dec.cause = mem_wr ? CODE_ADDR_ST : CODE_ADDR_LD;
    end else if (f_ovf) begin
      dec.kind  = KIND_OVF;
      dec.cause = CODE_OVF;
    end
  end

endmodule

// File: rtl/excvec_target.sv
module excvec_target
  import excvec_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter logic [XLEN-1:0] VEC_BASE    = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STRIDE  = 32'h0000_0020,
  parameter logic [XLEN-1:0] SINGLE_BASE = 32'hC000_0180
) (
  input  exc_kind_e       kind,
  input  logic            vec_mode,
  output logic [XLEN-1:0] target
);

  localparam int SLOTS = 1 << KIND_W;

  logic [XLEN-1:0] table_q [SLOTS];

  // One slot per fault kind; unused encodings fall back to the single entry.
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_KINDS) begin : g_vec
      assign table_q[g] = VEC_BASE + XLEN'(g) * VEC_STRIDE;
    end else begin : g_pad
      assign table_q[g] = SINGLE_BASE;
    end
  end

  always_comb begin
    target = vec_mode ? table_q[kind] : SINGLE_BASE;
  end

endmodule

// File: rtl/excvec_capture.sv
module excvec_capture
  import excvec_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  exc_dec_t           dec,
  input  logic [XLEN-1:0]    pc_cur,
  input  logic               pc_advanced,
  input  logic [XLEN-1:0]    target,
  output logic               exc_strobe,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [XLEN-1:0]    exc_epc,
  output logic [XLEN-1:0]    handler_pc
);

  logic [XLEN-1:0] epc_fix;

  always_comb begin
    epc_fix = pc_advanced ? (pc_cur - XLEN'(INSTR_BYTES)) : pc_cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_strobe <= 1'b0;
      exc_cause  <= '0;
      exc_epc    <= '0;
      handler_pc <= '0;
    end else begin
      exc_strobe <= dec.hit;
      if (dec.hit) begin
        exc_cause  <= dec.cause;
        exc_epc    <= epc_fix;
        handler_pc <= target;
      end
    end
  end

endmodule

// File: rtl/excvec_unit.sv
module excvec_unit
  import excvec_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              ALIGN_BITS  = 2,
  parameter int              INSTR_BYTES = 4,
  parameter logic [XLEN-1:0] VEC_BASE    = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STRIDE  = 32'h0000_0020,
  parameter logic [XLEN-1:0] SINGLE_BASE = 32'hC000_0180
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [5:0]         opcode,
  input  logic               alu_ovf,
  input  logic               mem_rd,
  input  logic               mem_wr,
  input  logic [XLEN-1:0]    mem_addr,
  input  logic [XLEN-1:0]    pc_cur,
  input  logic               pc_advanced,
  input  logic               vec_mode,
  input  logic               reg_we_in,
  output logic               reg_we_out,
  output logic               mem_we_out,
  output logic               exc_strobe,
  output logic [4:0]         exc_cause,
  output logic [XLEN-1:0]    exc_epc,
  output logic [XLEN-1:0]    handler_pc
);

  exc_dec_t        dec;
  logic [XLEN-1:0] target;
  logic            commit_ok;

  excvec_detect #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_detect (
    .instr_valid (instr_valid),
    .squash      (exc_strobe),
    .opcode      (opcode),
    .alu_ovf     (alu_ovf),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_addr    (mem_addr),
    .dec         (dec)
  );

  excvec_target #(
    .XLEN(XLEN), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE),
    .SINGLE_BASE(SINGLE_BASE)
  ) u_target (
    .kind     (dec.kind),
    .vec_mode (vec_mode),
    .target   (target)
  );

  excvec_capture #(.XLEN(XLEN), .INSTR_BYTES(INSTR_BYTES)) u_capture (
    .clk         (clk),
    .rst         (rst),
    .dec         (dec),
    .pc_cur      (pc_cur),
    .pc_advanced (pc_advanced),
    .target      (target),
    .exc_strobe  (exc_strobe),
    .exc_cause   (exc_cause),
    .exc_epc     (exc_epc),
    .handler_pc  (handler_pc)
  );

  // Side effects commit only for a live, clean instruction.
  always_comb begin
    commit_ok  = instr_valid & ~exc_strobe & ~dec.hit;
    reg_we_out = commit_ok & reg_we_in;
    mem_we_out = commit_ok & mem_wr;
  end

endmodule

// File: rtl/excvec_checker.sv
module excvec_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            instr_valid,
  input logic [5:0]      opcode,
  input logic            alu_ovf,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] pc_cur,
  input logic            pc_advanced,
  input logic            vec_mode,
  input logic            reg_we_out,
  input logic            mem_we_out,
  input logic            exc_strobe,
  input logic [4:0]      exc_cause,
  input logic [XLEN-1:0] exc_epc,
  input logic [XLEN-1:0] handler_pc
);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && alu_ovf) |-> !reg_we_out);

  a_r4_store_blocked: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && mem_wr && mem_addr[1:0] != 2'b00) |-> !mem_we_out);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    exc_strobe |=> !exc_strobe);

  a_r10_flush_quiet: assert property (@(posedge clk) disable iff (rst)
    exc_strobe |-> (!reg_we_out && !mem_we_out));

  a_r12_idle: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |-> (!reg_we_out && !mem_we_out));

  a_r5_undef_first: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !exc_strobe && !excvec_pkg::opc_legal(opcode))
      |=> (exc_strobe && exc_cause == 5'd10));

  a_r2_store_code: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !exc_strobe && excvec_pkg::opc_legal(opcode) && mem_wr &&
     mem_addr[1:0] != 2'b00) |=> (exc_strobe && exc_cause == 5'd5));

  a_r9_epc_back: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !exc_strobe && alu_ovf && pc_advanced)
      |=> (exc_epc == $past(pc_cur) - 32'd4));

  a_r8_single_entry: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !exc_strobe && alu_ovf && !vec_mode)
      |=> (handler_pc == 32'hC000_0180));

endmodule

bind excvec_unit excvec_checker #(.XLEN(XLEN)) u_excvec_checker (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .opcode(opcode),
  .alu_ovf(alu_ovf), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
  .pc_cur(pc_cur), .pc_advanced(pc_advanced), .vec_mode(vec_mode),
  .reg_we_out(reg_we_out), .mem_we_out(mem_we_out), .exc_strobe(exc_strobe),
  .exc_cause(exc_cause), .exc_epc(exc_epc), .handler_pc(handler_pc)
);

// File: tb/tb_excvec_unit.sv
module tb_excvec_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid, alu_ovf, mem_rd, mem_wr, pc_advanced, vec_mode, reg_we_in;
  logic [5:0]  opcode;
  logic [31:0] mem_addr, pc_cur;
  logic        reg_we_out, mem_we_out, exc_strobe;
  logic [4:0]  exc_cause;
  logic [31:0] exc_epc, handler_pc;

  always #5 clk = ~clk;

  excvec_unit dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .opcode(opcode),
    .alu_ovf(alu_ovf), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .pc_cur(pc_cur), .pc_advanced(pc_advanced), .vec_mode(vec_mode),
    .reg_we_in(reg_we_in), .reg_we_out(reg_we_out), .mem_we_out(mem_we_out),
    .exc_strobe(exc_strobe), .exc_cause(exc_cause), .exc_epc(exc_epc),
    .handler_pc(handler_pc)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference state
  logic        m_strobe = 0;
  logic [4:0]  m_cause  = 0;
  logic [31:0] m_epc    = 0;
  logic [31:0] m_hand   = 0;
  string       m_ctag   = "R6";
  string       m_htag   = "R7";

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit known_op(logic [5:0] op);
    int legal_list[13] = '{0, 2, 3, 4, 5, 8, 9, 10, 12, 13, 15, 35, 43};
    foreach (legal_list[i]) if (int'(op) == legal_list[i]) return 1;
    return 0;
  endfunction

  task automatic cyc(bit v, logic [5:0] op, bit ovf, bit rd, bit wr,
                     logic [31:0] addr, logic [31:0] pc, bit adv, bit vm, bit rwe);
    bit u, a, o, f;
    @(negedge clk);
    instr_valid = v; opcode = op; alu_ovf = ovf; mem_rd = rd; mem_wr = wr;
    mem_addr = addr; pc_cur = pc; pc_advanced = adv; vec_mode = vm; reg_we_in = rwe;
    #1;
    u = v && !m_strobe && !known_op(op);
    a = v && !m_strobe && (rd || wr) && (addr[1:0] != 2'b00);
    o = v && !m_strobe && ovf;
    f = u || a || o;
    check(o ? "R3" : (f || m_strobe) ? "R4" : "R12", "reg_we_out",
          32'(reg_we_out), 32'(v && rwe && !m_strobe && !f));
    check(a ? "R4" : m_strobe ? "R10" : "R12", "mem_we_out",
          32'(mem_we_out), 32'(v && wr && !m_strobe && !f));
    // Next reference state
    if (f) begin
      m_cause = u ? 5'd10 : a ? (wr ? 5'd5 : 5'd4) : 5'd12;
      m_ctag  = u ? ((a || o) ? "R5" : "R1") : a ? (o ? "R5" : "R2") : "R6";
      m_epc   = adv ? pc - 32'd4 : pc;
      m_hand  = !vm ? 32'hC000_0180 :
                u ? 32'hC000_0000 : a ? 32'hC000_0040 : 32'hC000_0020;
      m_htag  = vm ? "R7" : "R8";
    end
    m_strobe = f;
    @(posedge clk);
    #1;
    check("R10", "exc_strobe", 32'(exc_strobe), 32'(m_strobe));
    check(m_ctag, "exc_cause", 32'(exc_cause), 32'(m_cause));
    check("R9", "exc_epc", exc_epc, m_epc);
    check(m_htag, "handler_pc", handler_pc, m_hand);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; instr_valid = 0; opcode = 0; alu_ovf = 0; mem_rd = 0; mem_wr = 0;
    mem_addr = 0; pc_cur = 0; pc_advanced = 0; vec_mode = 0; reg_we_in = 0;
    repeat (3) @(negedge clk);
    // R11: outputs zero under reset
    check("R11", "reset exc_strobe", 32'(exc_strobe), 0);
    check("R11", "reset exc_cause", 32'(exc_cause), 0);
    check("R11", "reset exc_epc", exc_epc, 0);
    check("R11", "reset handler_pc", handler_pc, 0);
    rst = 0;

    // R12: clean instructions and idle slots
    cyc(1, 6'h00, 0, 0, 0, 32'h0, 32'h100, 1, 1, 1);
    cyc(1, 6'h2B, 0, 0, 1, 32'h2000, 32'h104, 1, 1, 0);
    cyc(0, 6'h3F, 1, 0, 1, 32'h3, 32'h108, 1, 1, 1);
    // R1 undefined, vectored (R7) and single entry (R8)
    cyc(1, 6'h3F, 0, 0, 0, 32'h0, 32'h200, 1, 1, 1);
    cyc(0, 6'h00, 0, 0, 0, 32'h0, 32'h0, 0, 0, 0);
    cyc(1, 6'h11, 0, 0, 0, 32'h0, 32'h300, 0, 0, 1);
    cyc(0, 6'h00, 0, 0, 0, 32'h0, 32'h0, 0, 0, 0);
    // R3 overflow with and without PC correction (R9)
    cyc(1, 6'h08, 1, 0, 0, 32'h0, 32'h404, 1, 1, 1);
    cyc(0, 6'h00, 0, 0, 0, 32'h0, 32'h0, 0, 0, 0);
    cyc(1, 6'h00, 1, 0, 0, 32'h0, 32'h500, 0, 0, 1);
    cyc(0, 6'h00, 0, 0, 0, 32'h0, 32'h0, 0, 0, 0);
    // R2 unaligned load and store, R4 store blocked
    cyc(1, 6'h23, 0, 1, 0, 32'h1001, 32'h604, 1, 1, 1);
    cyc(0, 6'h00, 0, 0, 0, 32'h0, 32'h0, 0, 0, 0);
    cyc(1, 6'h2B, 0, 0, 1, 32'h1002, 32'h704, 1, 1, 0);
    cyc(0, 6'h00, 0, 0, 0, 32'h0, 32'h0, 0, 0, 0);
    // R5 priority cases
    cyc(1, 6'h3E, 1, 0, 1, 32'h3, 32'h804, 1, 1, 1);
    cyc(0, 6'h00, 0, 0, 0, 32'h0, 32'h0, 0, 0, 0);
    cyc(1, 6'h23, 1, 1, 0, 32'h2, 32'h904, 1, 1, 1);
    cyc(0, 6'h00, 0, 0, 0, 32'h0, 32'h0, 0, 0, 0);
    // R10 fault during strobe cycle is ignored
    cyc(1, 6'h08, 1, 0, 0, 32'h0, 32'hA04, 1, 1, 1);
    cyc(1, 6'h3F, 1, 0, 1, 32'h1, 32'hA08, 1, 0, 1);
    cyc(1, 6'h00, 0, 0, 0, 32'h0, 32'hA0C, 1, 1, 1);

    // Mixed stimulus; store bit masked by load bit (R6 covers all codes)
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      logic [5:0]  op;
      r  = $urandom;
      op = r[4] ? 6'(r[13:8]) : (r[5] ? 6'h23 : 6'h2B);
      cyc(r[0], op, r[1] & r[2], r[3], r[6] & ~r[3],
          {28'h0, r[19:16]}, {r[31:22], 22'h0}, r[7], r[9], r[10]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule